// File: doc/BRIEF.md
# Watch-Crystal Time Base with Tone Output

This block is a free-running binary divider that gives a chip a steady time reference. It usually counts a 32.768 kHz watch crystal. It can also count every cycle of the system clock, or count a strobe taken from another timer's prescaler. A fixed tap at the top of the divider produces a half-second tick for clock keeping. A second tick is taken from one of four lower taps, picked by a 2-bit select, and is used for short periodic work. With a crystal input the short tick comes roughly every 0.98 ms, 3.9 ms, 15.6 ms or 62.5 ms.

Each tick sets a sticky flag. A flag raises the shared interrupt request while its own enable is set. Software clears a flag with a one-cycle write pulse. The same divider also drives a square-wave tone output of 4 kHz or 2 kHz when fed from the crystal.

Everything runs in the system clock domain. The crystal and prescaler sources arrive as single-cycle strobes, one per source period. The divider advances on a system clock edge only while that edge's selected strobe is high.

Top module: `base_timer`

## Requirements
- R1: After reset both flags, the interrupt request and the tone output are low, and the divider count is zero.
- R2: The source select code picks what advances the divider: 0 = crystal strobe, 1 = every system clock, 2 = prescaler strobe, 3 = nothing. Strobes of an unselected source have no effect.
- R3: While the run input is low the divider holds its count, no flag sets and the tone output does not change.
- R4: The long flag sets on the step that takes the count from 16383 back to 0, which is every 16384 steps.
- R5: The short-interval select codes 0, 1, 2 and 3 set the short flag every 32, 128, 512 and 2048 steps. The first flag sets on step 32, 128, 512 or 2048 after reset.
- R6: A flag stays set until its clear pulse. A clear pulse in the same cycle as a tick leaves the flag set.
- R7: The interrupt request is high exactly when a set flag has its enable high.
- R8: With the tone enabled, tone select 0 gives a 50% square wave of period 8 steps. It equals bit 2 of the count, so it is low for steps 0-3 and high for steps 4-7. Tone select 1 gives period 16, equal to bit 3 of the count.
- R9: While the tone enable is low the tone output is held low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| src_sel_i | input | 2 | Step source: 0 crystal, 1 system clock, 2 prescaler, 3 off |
| xtal_stb_i | input | 1 | One-cycle strobe per crystal period |
| pre_stb_i | input | 1 | One-cycle strobe from the other timer's prescaler |
| run_i | input | 1 | Divider run enable |
| fast_sel_i | input | 2 | Short-interval tap select |
| buzz_en_i | input | 1 | Tone output enable |
| buzz_sel_i | input | 1 | Tone select: 0 divide-by-8, 1 divide-by-16 |
| long_ie_i | input | 1 | Long flag interrupt enable |
| fast_ie_i | input | 1 | Short flag interrupt enable |
| long_clr_i | input | 1 | Long flag clear pulse |
| fast_clr_i | input | 1 | Short flag clear pulse |
| long_flag_o | output | 1 | Long tick sticky flag |
| fast_flag_o | output | 1 | Short tick sticky flag |
| irq_o | output | 1 | Combined interrupt request |
| buzz_o | output | 1 | Tone square wave |

## Verification
For each short-interval code, the divider is run from reset for one step fewer than the interval and then for exactly the interval. A tap off by one bit, or a wrong select decode, shows up as an early or missing flag. The half-second tick is checked the same way at 16383 and 16384 steps.

Source selection is checked with interleaved strobes of the wrong source, so that a swapped select or an extra step is exposed. The tone is compared step by step over a full period for both selects, which separates the two tap bits and the phase.

A clear pulse is placed in the exact cycle of a repeat tick to check that set has priority. Enable and mask patterns are checked against the interrupt output.

// File: rtl/bt_pkg.sv
package bt_pkg;
  typedef enum logic [1:0] {
    SRC_XTAL = 2'd0,
    SRC_SYS  = 2'd1,
    SRC_PRE  = 2'd2,
    SRC_OFF  = 2'd3
  } bt_src_e;
endpackage

// File: rtl/bt_step_sel.sv
module bt_step_sel
  import bt_pkg::*;
(
  input  logic [1:0] src_sel_i,
  input  logic       run_i,
  input  logic       xtal_stb_i,
  input  logic       pre_stb_i,
  output logic       step_o
);
  bt_src_e src;
  logic    raw;

  assign src = bt_src_e'(src_sel_i);

  always_comb begin
    unique case (src)
      SRC_XTAL: raw = xtal_stb_i;
      SRC_SYS:  raw = 1'b1;
      SRC_PRE:  raw = pre_stb_i;
      default:  raw = 1'b0;
    endcase
  end

  assign step_o = run_i & raw;
endmodule

// File: rtl/bt_divider.sv
module bt_divider #(
  parameter int CNT_W     = 14,
  parameter int N_FAST    = 4,
  parameter int FAST_W0   = 5,
  parameter int FAST_STEP = 2,
  localparam int SEL_W    = $clog2(N_FAST)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             step_i,
  input  logic [SEL_W-1:0] fast_sel_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             long_tick_o,
  output logic             fast_tick_o
);
  logic [CNT_W-1:0]  cnt_q;
  logic [N_FAST-1:0] tap_full;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (step_i) cnt_q <= cnt_q + 1'b1;
  end

  for (genvar i = 0; i < N_FAST; i++) begin : g_tap
    localparam int TW = FAST_W0 + FAST_STEP * i;
    assign tap_full[i] = &cnt_q[TW-1:0];
  end

  assign cnt_o       = cnt_q;
  assign long_tick_o = step_i & (&cnt_q);
  assign fast_tick_o = step_i & tap_full[fast_sel_i];

  AST_CNT_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_i |=> $stable(cnt_q)); // R3
  AST_LONG_HAS_FAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    long_tick_o |-> fast_tick_o); // R5
endmodule

// File: rtl/bt_buzzer.sv
module bt_buzzer (
  input  logic       en_i,
  input  logic       sel_i,
  input  logic [1:0] bits_i,
  output logic       buzz_o
);
  // bits_i[0] toggles every 4 steps, bits_i[1] every 8
  assign buzz_o = en_i & (sel_i ? bits_i[1] : bits_i[0]);

  always_comb begin
    AST_BUZZ_QUIET: assert (en_i || !buzz_o); // R9
  end
endmodule

// File: rtl/bt_flag.sv
module bt_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  input  logic ie_i,
  output logic flag_o,
  output logic req_o
);
  logic flag_q;

  // set has priority over a coincident clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     flag_q <= 1'b0;
    else if (set_i)  flag_q <= 1'b1;
    else if (clr_i)  flag_q <= 1'b0;
  end

  assign flag_o = flag_q;
  assign req_o  = flag_q & ie_i;

  AST_FLAG_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> flag_q); // R6
  AST_FLAG_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !set_i) |=> !flag_q); // R6
  AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_q && !clr_i) |=> flag_q); // R6
endmodule

// File: rtl/base_timer.sv
module base_timer #(
  parameter int CNT_W     = 14,
  parameter int N_FAST    = 4,
  parameter int FAST_W0   = 5,
  parameter int FAST_STEP = 2,
  parameter int BUZZ_BIT  = 2,
  localparam int SEL_W    = $clog2(N_FAST)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       src_sel_i,
  input  logic             xtal_stb_i,
  input  logic             pre_stb_i,
  input  logic             run_i,
  input  logic [SEL_W-1:0] fast_sel_i,
  input  logic             buzz_en_i,
  input  logic             buzz_sel_i,
  input  logic             long_ie_i,
  input  logic             fast_ie_i,
  input  logic             long_clr_i,
  input  logic             fast_clr_i,
  output logic             long_flag_o,
  output logic             fast_flag_o,
  output logic             irq_o,
  output logic             buzz_o
);
  logic             step;
  logic [CNT_W-1:0] cnt;
  logic             long_tick, fast_tick;
  logic             long_req, fast_req;

  bt_step_sel u_step (
    .src_sel_i (src_sel_i),
    .run_i     (run_i),
    .xtal_stb_i(xtal_stb_i),
    .pre_stb_i (pre_stb_i),
    .step_o    (step)
  );

  bt_divider #(
    .CNT_W    (CNT_W),
    .N_FAST   (N_FAST),
    .FAST_W0  (FAST_W0),
    .FAST_STEP(FAST_STEP)
  ) u_div (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .step_i     (step),
    .fast_sel_i (fast_sel_i),
    .cnt_o      (cnt),
    .long_tick_o(long_tick),
    .fast_tick_o(fast_tick)
  );

  bt_buzzer u_buzz (
    .en_i  (buzz_en_i),
    .sel_i (buzz_sel_i),
    .bits_i(cnt[BUZZ_BIT+1:BUZZ_BIT]),
    .buzz_o(buzz_o)
  );

  bt_flag u_long (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (long_tick),
    .clr_i (long_clr_i),
    .ie_i  (long_ie_i),
    .flag_o(long_flag_o),
    .req_o (long_req)
  );

  bt_flag u_fast (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (fast_tick),
    .clr_i (fast_clr_i),
    .ie_i  (fast_ie_i),
    .flag_o(fast_flag_o),
    .req_o (fast_req)
  );

  assign irq_o = long_req | fast_req;

  AST_IRQ_MASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!long_ie_i && !fast_ie_i) |-> !irq_o); // R7
  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (long_flag_o || fast_flag_o)); // R7
  AST_NO_STEP_NO_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !long_flag_o && !long_clr_i) |=> !long_flag_o); // R3
endmodule

// File: tb/tb_base_timer.sv
`timescale 1ns/1ps
module tb_base_timer;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] src_sel = 2'd1;
  logic xtal = 0, pre = 0, run = 0;
  logic [1:0] fast_sel = 0;
  logic buzz_en = 0, buzz_sel = 0;
  logic long_ie = 0, fast_ie = 0, long_clr = 0, fast_clr = 0;
  logic long_flag, fast_flag, irq, buzz;

  int checks = 0;
  int fails = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;

  base_timer dut (
    .clk_i(clk), .rst_ni(rst_n), .src_sel_i(src_sel), .xtal_stb_i(xtal),
    .pre_stb_i(pre), .run_i(run), .fast_sel_i(fast_sel), .buzz_en_i(buzz_en),
    .buzz_sel_i(buzz_sel), .long_ie_i(long_ie), .fast_ie_i(fast_ie),
    .long_clr_i(long_clr), .fast_clr_i(fast_clr), .long_flag_o(long_flag),
    .fast_flag_o(fast_flag), .irq_o(irq), .buzz_o(buzz)
  );

  localparam int NV = 8;
  localparam int V_SEL [NV] = '{0, 0, 1, 1, 2, 2, 3, 3};
  localparam int V_CYC [NV] = '{31, 32, 127, 128, 511, 512, 2047, 2048};
  localparam int V_EXP [NV] = '{0, 1, 0, 1, 0, 1, 0, 1};

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic steps(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0;
    src_sel = 2'd1; xtal = 0; pre = 0; run = 1; fast_sel = 0;
    buzz_en = 0; buzz_sel = 0; long_ie = 0; fast_ie = 0;
    long_clr = 0; fast_clr = 0;
    @(negedge clk);
    rst_n = 1;
  endtask

  task automatic pulse_xtal(input int n);
    for (int i = 0; i < n; i++) begin
      xtal = 1; @(negedge clk); xtal = 0;
      repeat (3) @(negedge clk);
    end
  endtask

  task automatic pulse_pre(input int n);
    for (int i = 0; i < n; i++) begin
      pre = 1; @(negedge clk); pre = 0;
      repeat (2) @(negedge clk);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 200000) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=%0d expected<=200000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    run = 0;
    do_reset();
    run = 0;
    @(negedge clk);
    chk("R1 long_flag", long_flag, 0);
    chk("R1 fast_flag", fast_flag, 0);
    chk("R1 irq", irq, 0);
    chk("R1 buzz", buzz, 0);

    // R5 short interval table walk
    for (int i = 0; i < NV; i++) begin
      do_reset();
      fast_sel = V_SEL[i][1:0];
      steps(V_CYC[i]);
      chk($sformatf("R5 sel=%0d n=%0d", V_SEL[i], V_CYC[i]), fast_flag, V_EXP[i]);
    end

    // R4 long tick boundary
    do_reset();
    fast_sel = 2'd3;
    steps(16383);
    chk("R4 long before 16384", long_flag, 0);
    steps(1);
    chk("R4 long at 16384", long_flag, 1);

    // R7 interrupt gating
    chk("R7 irq masked", irq, 0);
    long_ie = 1;
    @(negedge clk);
    chk("R7 irq long enabled", irq, 1);
    long_ie = 0; long_clr = 1;
    @(negedge clk);
    long_clr = 0;
    chk("R6 long cleared", long_flag, 0);
    fast_ie = 1;
    @(negedge clk);
    chk("R7 irq fast enabled", irq, 1);

    // R6 clear coincident with tick: set wins
    do_reset();
    steps(32);
    chk("R6 fast set", fast_flag, 1);
    steps(20);
    chk("R6 fast sticky", fast_flag, 1);
    repeat (11) @(negedge clk);
    fast_clr = 1;               // spans the 64th step
    @(negedge clk);
    fast_clr = 0;
    chk("R6 set beats clear", fast_flag, 1);
    fast_clr = 1;
    @(negedge clk);
    fast_clr = 0;
    chk("R6 clear alone", fast_flag, 0);

    // R2 crystal source ignores system cycles and prescaler strobes
    do_reset();
    src_sel = 2'd0;
    pre = 1;
    steps(40);
    pre = 0;
    chk("R2 xtal src ignores pre", fast_flag, 0);
    pulse_xtal(31);
    chk("R2 xtal 31 strobes", fast_flag, 0);
    pulse_xtal(1);
    chk("R2 xtal 32 strobes", fast_flag, 1);

    // R2 prescaler source
    do_reset();
    src_sel = 2'd2;
    pulse_xtal(40);
    chk("R2 pre src ignores xtal", fast_flag, 0);
    pulse_pre(31);
    chk("R2 pre 31 strobes", fast_flag, 0);
    pulse_pre(1);
    chk("R2 pre 32 strobes", fast_flag, 1);

    // R2 off code
    do_reset();
    src_sel = 2'd3;
    xtal = 1; pre = 1;
    steps(40);
    xtal = 0; pre = 0;
    chk("R2 off code no count", fast_flag, 0);

    // R3 run low freezes divider and tone
    do_reset();
    steps(5);                  // count = 5 -> bit2 high
    run = 0;
    buzz_en = 1;
    @(negedge clk);
    chk("R3 tone level at hold", buzz, 1);
    steps(60);
    chk("R3 no flag while stopped", fast_flag, 0);
    chk("R3 tone frozen", buzz, 1);
    run = 1;
    steps(27);
    chk("R3 resumes at 32 steps", fast_flag, 1);

    // R8 tone waveform, both selects
    do_reset();
    buzz_en = 1; buzz_sel = 0;
    for (int k = 0; k < 16; k++) begin
      chk($sformatf("R8 div8 step %0d", k), buzz, (k >> 2) & 1);
      steps(1);
    end
    do_reset();
    buzz_en = 1; buzz_sel = 1;
    for (int k = 0; k < 32; k++) begin
      chk($sformatf("R8 div16 step %0d", k), buzz, (k >> 3) & 1);
      steps(1);
    end

    // R9 tone disabled stays low
    do_reset();
    buzz_en = 0;
    for (int k = 0; k < 16; k++) begin
      chk("R9 tone off", buzz, 0);
      steps(1);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule